// File: doc/BRIEF.md
# 64-bit Compare-Match Event Timer

This block is a free-running 64-bit up-counter with a single 64-bit comparator. It sits on a simple 32-bit register bus. The counter advances by one on every clock edge while counting is enabled. There is no prescaler. Both the counter and the comparator are seen by software as a low and a high 32-bit word. The high word takes the carry out of the low word on the same edge, so software can read high, low, high and retry the read if the high word moved.

When compare is enabled, the comparator latches a sticky event flag whenever the count is at or beyond the compare value. Software clears the flag by writing a one to it. The interrupt output is the flag gated by an interrupt-enable bit.

In periodic mode, every match also adds a programmable step to the comparator in the same cycle. This re-arms the next event without software help. For a one-shot event, software writes the comparator while compare is disabled and then enables it.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset the counter, control, comparator, step register and event flag are all zero, every register reads 0, and `irq` is low.
- R2: With control bit 0 (run) set, the counter increases by exactly one per clock. With run clear, the counter holds its value.
- R3: The 64-bit counter is one register, so the carry from low word 0xFFFFFFFF into the high word appears on the same clock edge that the low word wraps to zero.
- R4: A write to offset 0x00 (count low) or 0x04 (count high) replaces that half and leaves the other half unchanged. No increment is applied in the cycle of a counter write, even while running.
- R5: With control bit 1 (compare enable) set, the event flag (status offset 0x0C, bit 0) is set on the clock edge after the registered count first equals the comparator value.
- R6: With compare enable clear, the event flag is never set, whatever values are written to the comparator halves (offsets 0x10 and 0x14).
- R7: The match test is greater-or-equal: enabling compare while the count is already above the comparator sets the flag one cycle later.
- R8: With compare enable and control bit 3 (periodic) set, each match adds the step register (offset 0x18, zero-extended) to the comparator on the same edge that sets the flag.
- R9: Writing 1 to status bit 0 clears the event flag. Writing 0 to it has no effect.
- R10: If a match is true in the same cycle as a clear write, the flag stays set.
- R11: `irq` equals the event flag ANDed with control bit 2 (interrupt enable) and needs no extra cycle.
- R12: Control (offset 0x08) reads back bits 3:0 with the upper bits as zero. The comparator halves and the step register read back their written values. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt: event flag gated by interrupt enable |

## Verification
The properties assume that a write strobe carries one legal offset and is held for exactly one clock. They also assume the status clear and the counter writes come only through the bus, so a cycle with no write to a register leaves that register to the timer logic alone. The stimulus keeps to this: it raises `bus_we` for a single cycle between falling edges and changes the address only while the strobe is low. Comparator and counter reprogramming is done with compare disabled, except where the test deliberately enables compare on a count that is already past the comparator.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    // Register offsets (byte addresses) seen by software
    localparam int unsigned OFS_CNT_LO = 32'h00;
    localparam int unsigned OFS_CNT_HI = 32'h04;
    localparam int unsigned OFS_CTRL   = 32'h08;
    localparam int unsigned OFS_STAT   = 32'h0C;
    localparam int unsigned OFS_CMP_LO = 32'h10;
    localparam int unsigned OFS_CMP_HI = 32'h14;
    localparam int unsigned OFS_STEP   = 32'h18;

    // Control field positions
    localparam int unsigned CTRL_W  = 4;
    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_CMP  = 1;
    localparam int unsigned CB_IEN  = 2;
    localparam int unsigned CB_AUTO = 3;

    // Per-half write strobes for a split 64-bit register
    typedef struct packed {
        logic hi;
        logic lo;
    } half_we_t;

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  cmp_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] step_o,
    output half_we_t          cnt_we_o,
    output half_we_t          cmp_we_o,
    output logic              clr_o
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] step;
    } regs_t;

    regs_t regs_d, regs_q;

    logic hit_cnt_lo, hit_cnt_hi, hit_ctrl, hit_stat;
    logic hit_cmp_lo, hit_cmp_hi, hit_step;

    always_comb begin
        hit_cnt_lo = (bus_addr == ADDR_W'(OFS_CNT_LO));
        hit_cnt_hi = (bus_addr == ADDR_W'(OFS_CNT_HI));
        hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_stat   = (bus_addr == ADDR_W'(OFS_STAT));
        hit_cmp_lo = (bus_addr == ADDR_W'(OFS_CMP_LO));
        hit_cmp_hi = (bus_addr == ADDR_W'(OFS_CMP_HI));
        hit_step   = (bus_addr == ADDR_W'(OFS_STEP));
    end

    // Next-state for the locally held registers and write strobes
    always_comb begin
        regs_d = regs_q;
        if (bus_we && hit_ctrl) begin
            regs_d.ctrl = bus_wdata[CTRL_W-1:0];
        end
        if (bus_we && hit_step) begin
            regs_d.step = bus_wdata;
        end
        cnt_we_o.lo = bus_we && hit_cnt_lo;
        cnt_we_o.hi = bus_we && hit_cnt_hi;
        cmp_we_o.lo = bus_we && hit_cmp_lo;
        cmp_we_o.hi = bus_we && hit_cmp_hi;
        clr_o       = bus_we && hit_stat && bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata_o = '0;
        unique case (1'b1)
            hit_cnt_lo: rdata_o = cnt_i[DATA_W-1:0];
            hit_cnt_hi: rdata_o = cnt_i[CNT_W-1:DATA_W];
            hit_ctrl:   rdata_o = DATA_W'(regs_q.ctrl);
            hit_stat:   rdata_o = DATA_W'(flag_i);
            hit_cmp_lo: rdata_o = cmp_i[DATA_W-1:0];
            hit_cmp_hi: rdata_o = cmp_i[CNT_W-1:DATA_W];
            hit_step:   rdata_o = regs_q.step;
            default:    rdata_o = '0;
        endcase
    end

    assign ctrl_o = regs_q.ctrl;
    assign step_o = regs_q.step;

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
    import cmp_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  half_we_t          we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    // A half write wins over the increment for that cycle
    always_comb begin
        st_d = st_q;
        if (we_i.lo || we_i.hi) begin
            if (we_i.lo) begin
                st_d.cnt[DATA_W-1:0] = wdata_i;
            end
            if (we_i.hi) begin
                st_d.cnt[CNT_W-1:DATA_W] = wdata_i;
            end
        end else if (run_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match
    import cmp_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              en_i,
    input  logic              auto_i,
    input  logic [DATA_W-1:0] step_i,
    input  half_we_t          we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              clr_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              flag_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
    } match_st_t;

    match_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit  = en_i && (cnt_i >= st_q.cmp);
        st_d = st_q;

        // Comparator: software write first, else periodic re-arm
        if (we_i.lo || we_i.hi) begin
            if (we_i.lo) begin
                st_d.cmp[DATA_W-1:0] = wdata_i;
            end
            if (we_i.hi) begin
                st_d.cmp[CNT_W-1:DATA_W] = wdata_i;
            end
        end else if (hit && auto_i) begin
            st_d.cmp = st_q.cmp + CNT_W'(step_i);
        end

        // Sticky flag: a live match overrides a clear
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o  = st_q.cmp;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] step_q;
    logic              flag_q;
    half_we_t          cnt_we;
    half_we_t          cmp_we;
    logic              flag_clr;

    cmp_timer_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt_q),
        .cmp_i     (cmp_q),
        .flag_i    (flag_q),
        .rdata_o   (bus_rdata),
        .ctrl_o    (ctrl_q),
        .step_o    (step_q),
        .cnt_we_o  (cnt_we),
        .cmp_we_o  (cmp_we),
        .clr_o     (flag_clr)
    );

    cmp_timer_count #(
        .DATA_W (DATA_W)
    ) count_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl_q[CB_RUN]),
        .we_i    (cnt_we),
        .wdata_i (bus_wdata),
        .cnt_o   (cnt_q)
    );

    cmp_timer_match #(
        .DATA_W (DATA_W)
    ) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_q),
        .en_i    (ctrl_q[CB_CMP]),
        .auto_i  (ctrl_q[CB_AUTO]),
        .step_i  (step_q),
        .we_i    (cmp_we),
        .wdata_i (bus_wdata),
        .clr_i   (flag_clr),
        .cmp_o   (cmp_q),
        .flag_o  (flag_q)
    );

    assign irq = flag_q && ctrl_q[CB_IEN];

endmodule

// File: rtl/cmp_event_timer_chk.sv
module cmp_event_timer_chk
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              wr_bit0,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [DATA_W-1:0] step,
    input logic [CTRL_W-1:0] ctrl,
    input logic              flag
);

    logic wr_cnt, wr_cmp, wr_clr, match_now;

    always_comb begin
        wr_cnt = bus_we && ((bus_addr == ADDR_W'(OFS_CNT_LO)) ||
                            (bus_addr == ADDR_W'(OFS_CNT_HI)));
        wr_cmp = bus_we && ((bus_addr == ADDR_W'(OFS_CMP_LO)) ||
                            (bus_addr == ADDR_W'(OFS_CMP_HI)));
        wr_clr = bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && wr_bit0;
        match_now = ctrl[CB_CMP] && (cnt >= cmp);
    end

    // R2: one step per clock while running
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_RUN] && !wr_cnt) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2: hold while stopped
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_RUN] && !wr_cnt) |=> $stable(cnt));

    // R5 and R7: a match sets the flag on the next edge
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_now |=> flag);

    // R6: no flag rises while compare is off
    p_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CB_CMP] && !flag) |=> !flag);

    // R8: periodic re-arm by the step value
    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_now && ctrl[CB_AUTO] && !wr_cmp)
            |=> (cmp == $past(cmp) + CNT_W'($past(step))));

    // R9: clear without a match drops the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !match_now) |=> !flag);

    // R9 and R10: flag is sticky unless cleared
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_clr) |=> flag);

    // R11: interrupt needs the flag and the enable
    p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ctrl[CB_IEN]));

endmodule

bind cmp_event_timer cmp_event_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .wr_bit0  (bus_wdata[0]),
    .irq      (irq),
    .cnt      (cnt_q),
    .cmp      (cmp_q),
    .step     (step_q),
    .ctrl     (ctrl_q),
    .flag     (flag_q)
);

// File: tb/cmp_event_timer_tb_top.sv
module cmp_event_timer_tb_top;

    localparam int unsigned AW = 5;
    localparam int unsigned DW = 32;
    localparam int unsigned WATCHDOG = 20000;

    localparam logic [AW-1:0] A_CLO  = 5'h00;
    localparam logic [AW-1:0] A_CHI  = 5'h04;
    localparam logic [AW-1:0] A_CTRL = 5'h08;
    localparam logic [AW-1:0] A_STAT = 5'h0C;
    localparam logic [AW-1:0] A_MLO  = 5'h10;
    localparam logic [AW-1:0] A_MHI  = 5'h14;
    localparam logic [AW-1:0] A_STEP = 5'h18;
    localparam logic [AW-1:0] A_NONE = 5'h1C;

    // op: 0 write, 1 read and compare, 2 idle one clock, 3 compare irq
    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [7:0]    req;
    } vec_t;

    localparam int NVEC = 36;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, A_CTRL, 32'h0000_0000, 8'd0},
        '{2'd0, A_CLO,  32'h0000_0010, 8'd0},
        '{2'd0, A_CHI,  32'h0000_0001, 8'd0},
        '{2'd1, A_CLO,  32'h0000_0010, 8'd4},   // R4 low half
        '{2'd1, A_CHI,  32'h0000_0001, 8'd4},   // R4 high half
        '{2'd0, A_MLO,  32'h0000_0005, 8'd0},
        '{2'd0, A_MHI,  32'h0000_0001, 8'd0},
        '{2'd2, A_CLO,  32'h0000_0000, 8'd0},
        '{2'd1, A_STAT, 32'h0000_0000, 8'd6},   // R6 compare off, no flag
        '{2'd0, A_STEP, 32'h0000_0020, 8'd0},
        '{2'd1, A_STEP, 32'h0000_0020, 8'd12},  // R12 step readback
        '{2'd1, A_MLO,  32'h0000_0005, 8'd12},  // R12 comparator low
        '{2'd1, A_MHI,  32'h0000_0001, 8'd12},  // R12 comparator high
        '{2'd0, A_CTRL, 32'h0000_0002, 8'd0},
        '{2'd2, A_CLO,  32'h0000_0000, 8'd0},
        '{2'd1, A_STAT, 32'h0000_0001, 8'd7},   // R7 count already past
        '{2'd0, A_STAT, 32'h0000_0000, 8'd0},
        '{2'd1, A_STAT, 32'h0000_0001, 8'd9},   // R9 writing 0 no effect
        '{2'd0, A_STAT, 32'h0000_0001, 8'd0},
        '{2'd1, A_STAT, 32'h0000_0001, 8'd10},  // R10 clear lost to match
        '{2'd0, A_CTRL, 32'h0000_0000, 8'd0},
        '{2'd0, A_STAT, 32'h0000_0001, 8'd0},
        '{2'd1, A_STAT, 32'h0000_0000, 8'd9},   // R9 clear works
        '{2'd0, A_CTRL, 32'h0000_000A, 8'd0},
        '{2'd2, A_CLO,  32'h0000_0000, 8'd0},
        '{2'd2, A_CLO,  32'h0000_0000, 8'd0},
        '{2'd1, A_MLO,  32'h0000_0025, 8'd8},   // R8 re-armed once
        '{2'd1, A_MHI,  32'h0000_0001, 8'd8},   // R8 high unchanged
        '{2'd1, A_STAT, 32'h0000_0001, 8'd8},   // R8 flag with re-arm
        '{2'd3, A_CLO,  32'h0000_0000, 8'd11},  // R11 masked
        '{2'd0, A_CTRL, 32'h0000_000E, 8'd0},
        '{2'd3, A_CLO,  32'h0000_0001, 8'd11},  // R11 enabled
        '{2'd0, A_STAT, 32'h0000_0001, 8'd0},
        '{2'd3, A_CLO,  32'h0000_0000, 8'd11},  // R11 after clear
        '{2'd0, A_CTRL, 32'hFFFF_FFF4, 8'd0},
        '{2'd1, A_CTRL, 32'h0000_0004, 8'd12}   // R12 upper control bits zero
    };

    logic          clk;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_chk;
    int n_err;
    bit done;

    cmp_event_timer #(
        .ADDR_W (AW),
        .DATA_W (DW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input string tag, input logic [AW-1:0] a,
                             input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        n_chk     = 0;
        n_err     = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state of every register and irq
        expect_rd("R1 count low",  A_CLO,  32'h0);
        expect_rd("R1 count high", A_CHI,  32'h0);
        expect_rd("R1 control",    A_CTRL, 32'h0);
        expect_rd("R1 status",     A_STAT, 32'h0);
        expect_rd("R1 cmp low",    A_MLO,  32'h0);
        expect_rd("R1 cmp high",   A_MHI,  32'h0);
        expect_rd("R1 step",       A_STEP, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2: count ten clocks, then stop and hold
        wr(A_CTRL, 32'h1);
        expect_rd("R2 start", A_CLO, 32'h0);
        idle(10);
        expect_rd("R2 ten ticks", A_CLO, 32'd10);
        wr(A_CTRL, 32'h0);
        idle(5);
        expect_rd("R2 held", A_CLO, 32'd11);

        // R3: carry into high word on the wrap edge
        wr(A_CLO, 32'hFFFF_FFFE);
        wr(A_CHI, 32'h0000_0007);
        wr(A_CTRL, 32'h1);
        idle(1);
        expect_rd("R3 low at max", A_CLO, 32'hFFFF_FFFF);
        expect_rd("R3 high before", A_CHI, 32'h7);
        idle(1);
        expect_rd("R3 low wrapped", A_CLO, 32'h0);
        expect_rd("R3 high carried", A_CHI, 32'h8);

        // R4: write while running replaces the half, no increment
        wr(A_CLO, 32'h0000_0100);
        expect_rd("R4 write wins", A_CLO, 32'h100);
        expect_rd("R4 other half", A_CHI, 32'h8);
        idle(1);
        expect_rd("R4 resumes", A_CLO, 32'h101);
        wr(A_CTRL, 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [DW-1:0] v;
            case (VEC[i].op)
                2'd0: wr(VEC[i].addr, VEC[i].data);
                2'd1: begin
                    rd(VEC[i].addr, v);
                    n_chk++;
                    if (v !== VEC[i].data) begin
                        n_err++;
                        $display("FAIL R%0d row %0d: got 0x%08h expected 0x%08h",
                                 VEC[i].req, i, v, VEC[i].data);
                    end
                end
                2'd2: idle(1);
                default: begin
                    n_chk++;
                    if (irq !== VEC[i].data[0]) begin
                        n_err++;
                        $display("FAIL R%0d row %0d irq: got %0b expected %0b",
                                 VEC[i].req, i, irq, VEC[i].data[0]);
                    end
                end
            endcase
        end
        // R12: unmapped offset reads zero
        expect_rd("R12 unmapped", A_NONE, 32'h0);

        // R5: exact edge of an equality match while counting
        wr(A_CTRL, 32'h0);
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_MLO, 32'h5);
        wr(A_MHI, 32'h0);
        wr(A_STAT, 32'h1);
        wr(A_CTRL, 32'h3);
        idle(5);
        expect_rd("R5 count at cmp", A_CLO, 32'h5);
        expect_rd("R5 not yet", A_STAT, 32'h0);
        idle(1);
        expect_rd("R5 flag set", A_STAT, 32'h1);

        // R8: periodic events while counting
        wr(A_CTRL, 32'h0);
        wr(A_CLO, 32'h0);
        wr(A_MLO, 32'h4);
        wr(A_STEP, 32'h6);
        wr(A_STAT, 32'h1);
        wr(A_CTRL, 32'hB);
        idle(5);
        expect_rd("R8 first event", A_STAT, 32'h1);
        expect_rd("R8 first re-arm", A_MLO, 32'd10);
        wr(A_STAT, 32'h1);
        expect_rd("R9 cleared between events", A_STAT, 32'h0);
        idle(4);
        expect_rd("R8 before second", A_STAT, 32'h0);
        idle(1);
        expect_rd("R8 second event", A_STAT, 32'h1);
        expect_rd("R8 second re-arm", A_MLO, 32'd16);
        wr(A_CTRL, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule